// File: doc/BRIEF.md
# Host Cycle to User-Logic Handshake Bridge

The bridge turns a host processor's bus cycle into a start/end handshake with user logic. When the host raises its select, the bridge captures the 4-bit location and the direction of the cycle. It drives them to the user logic and then raises a start strobe. It then holds the host in wait states until the user logic answers with an end strobe. At that point the bridge gives the host a single-cycle acknowledge. The user logic alone sets the length of a cycle. Tying the end input to the start output gives the shortest cycle the bridge allows.

The 16 user locations have no fixed hardware registers behind them. User logic may build registers from them or use the decoded location as a control. Data moves directly between the pins and the user logic, so the bridge carries no data. An active-low interrupt request from the user logic drives an active-high host interrupt output. This path does not depend on any transfer in progress.

The end and interrupt inputs each pass through a two-flop synchronizer, so the user logic may run on a clock unrelated to the host clock. Only one cycle is in flight at a time.

Top module: `ulb_bridge`

## Requirements
- R1: While reset is active, and in the first cycle after it, usr_start, hst_ack and hst_irq are 0, and usr_addr and usr_rd are 0.
- R2: On the rising edge where the idle bridge first samples hst_sel high, usr_addr takes hst_addr. On that same edge usr_rd takes hst_rd, which is 1 for a host read and 0 for a host write. For one cycle the two are driven with usr_start still 0.
- R3: usr_start rises on the second rising edge after the edge where hst_sel was first sampled high.
- R4: usr_addr and usr_rd hold their captured values until the cycle is acknowledged, whatever hst_addr and hst_rd do in the meantime.
- R5: hst_ack is high for exactly one cycle. It rises on the third rising edge after usr_end is first sampled high during usr_start. usr_start falls on that same edge.
- R6: With usr_end tied to usr_start, hst_ack rises on the fifth rising edge after hst_sel is first sampled high.
- R7: After an acknowledge, no new usr_start is raised while hst_sel stays high. A new cycle starts only after hst_sel has been seen low and the synchronized end input is low.
- R8: hst_irq equals the inverse of usr_irq_n as sampled two rising edges earlier. This holds during host cycles and between them, and the request stays forwarded for as long as it is held.
- R9: usr_start stays high, with hst_ack low, for as many cycles as usr_end stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host cycle select, held until acknowledged |
| hst_rd | input | 1 | Host direction: 1 read, 0 write |
| hst_addr | input | 4 | Host user-location address |
| hst_ack | output | 1 | Single-cycle acknowledge to the host |
| hst_irq | output | 1 | Active-high interrupt to the host |
| usr_addr | output | 4 | Location presented to user logic |
| usr_rd | output | 1 | Direction to user logic: 1 read, 0 write |
| usr_start | output | 1 | Active-high start strobe |
| usr_end | input | 1 | Active-high end strobe from user logic |
| usr_irq_n | input | 1 | Active-low interrupt request from user logic |

## Verification
Each result falls a fixed number of edges after its stimulus. Address and direction are due one edge after select is sampled, and start two edges after it. The acknowledge is due three edges after end is sampled, which makes five edges after select in the tied case. The interrupt is due two edges after the request changes. The bench drives inputs on falling edges and counts falling edges from the stimulus. At each falling edge it compares the outputs with the value due in that cycle, so it also checks the cycles where an output must not yet have moved.

// File: rtl/ulb_pkg.sv
package ulb_pkg;

  typedef enum logic [2:0] {
    ULB_IDLE  = 3'd0,
    ULB_SETUP = 3'd1,
    ULB_START = 3'd2,
    ULB_ACK   = 3'd3,
    ULB_DRAIN = 3'd4
  } ulb_state_e;

  localparam int unsigned ULB_SYNC_DEPTH = 2;

endpackage

// File: rtl/ulb_rst_sync.sv
module ulb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = chain_q[STAGES-1];

endmodule

// File: rtl/ulb_sync.sv
module ulb_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage_q[s] <= RST_VAL;
          end else begin
            stage_q[s] <= din;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage_q[s] <= RST_VAL;
          end else begin
            stage_q[s] <= stage_q[s-1];
          end
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ulb_seq.sv
module ulb_seq
  import ulb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel,
  input  logic              hst_rd,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic              end_sync,
  output logic              hst_ack,
  output logic [ADDR_W-1:0] usr_addr,
  output logic              usr_rd,
  output logic              usr_start
);

  ulb_state_e        state_q, state_d;
  logic              cap_en;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      ULB_IDLE: begin
        if (hst_sel) begin
          cap_en  = 1'b1;
          state_d = ULB_SETUP;
        end
      end
      ULB_SETUP: state_d = ULB_START;
      ULB_START: begin
        if (end_sync) begin
          state_d = ULB_ACK;
        end
      end
      ULB_ACK:   state_d = ULB_DRAIN;
      ULB_DRAIN: begin
        if (!hst_sel && !end_sync) begin
          state_d = ULB_IDLE;
        end
      end
      default:   state_d = ULB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ULB_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else if (cap_en) begin
      addr_q <= hst_addr;
      rd_q   <= hst_rd;
    end
  end

  assign usr_addr  = addr_q;
  assign usr_rd    = rd_q;
  assign usr_start = (state_q == ULB_START);
  assign hst_ack   = (state_q == ULB_ACK);

  // R5: acknowledge lasts a single cycle
  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ack |=> !hst_ack);

  // R5: acknowledge only follows a start cycle that saw end
  assert_ack_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hst_ack) |-> $past(usr_start) && $past(end_sync));

  // R4: location and direction frozen while start is raised
  assert_start_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_start || hst_ack) |-> $stable(usr_addr) && $stable(usr_rd));

  // R9: start is held while end has not arrived
  assert_start_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_start && !end_sync) |=> usr_start && !hst_ack);

  // R7: no restart while select is still held after acknowledge
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ULB_DRAIN && hst_sel) |=> !usr_start);

  // R3: start is always preceded by a setup cycle without start
  assert_start_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usr_start) |-> $past(state_q) == ULB_SETUP);

endmodule

// File: rtl/ulb_bridge.sv
module ulb_bridge
  import ulb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel,
  input  logic              hst_rd,
  input  logic [ADDR_W-1:0] hst_addr,
  output logic              hst_ack,
  output logic              hst_irq,
  output logic [ADDR_W-1:0] usr_addr,
  output logic              usr_rd,
  output logic              usr_start,
  input  logic              usr_end,
  input  logic              usr_irq_n
);

  localparam int unsigned SYNC_W = 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = 2'b10; // {irq_n idle high, end idle low}

  logic              rst_int_n;
  logic [SYNC_W-1:0] sync_in;
  logic [SYNC_W-1:0] sync_out;
  logic              end_sync;
  logic              irq_n_sync;

  ulb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  assign sync_in = {usr_irq_n, usr_end};

  ulb_sync #(
    .WIDTH   (SYNC_W),
    .STAGES  (ULB_SYNC_DEPTH),
    .RST_VAL (SYNC_RST)
  ) i_in_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (sync_in),
    .dout  (sync_out)
  );

  assign end_sync   = sync_out[0];
  assign irq_n_sync = sync_out[1];
  assign hst_irq    = ~irq_n_sync;

  ulb_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hst_sel   (hst_sel),
    .hst_rd    (hst_rd),
    .hst_addr  (hst_addr),
    .end_sync  (end_sync),
    .hst_ack   (hst_ack),
    .usr_addr  (usr_addr),
    .usr_rd    (usr_rd),
    .usr_start (usr_start)
  );

  // checker-only age counter so the two-edge look-back stays inside reset history
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R8: interrupt output follows the request two edges later
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q == 2'd3) |-> (hst_irq == !$past(usr_irq_n, 2)));

  // R1: quiet outputs right after reset release
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q == 2'd0) |-> !usr_start && !hst_ack);

endmodule

// File: tb/test_ulb_bridge.sv
module test_ulb_bridge;

  logic       clk;
  logic       rst_n;
  logic       hst_sel;
  logic       hst_rd;
  logic [3:0] hst_addr;
  logic       hst_ack;
  logic       hst_irq;
  logic [3:0] usr_addr;
  logic       usr_rd;
  logic       usr_start;
  logic       usr_end;
  logic       usr_irq_n;
  logic       end_drv;
  logic       tie;

  int n_chk;
  int n_bad;
  bit finished;

  assign usr_end = tie ? usr_start : end_drv;

  ulb_bridge i_ulb_bridge (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_sel   (hst_sel),
    .hst_rd    (hst_rd),
    .hst_addr  (hst_addr),
    .hst_ack   (hst_ack),
    .hst_irq   (hst_irq),
    .usr_addr  (usr_addr),
    .usr_rd    (usr_rd),
    .usr_start (usr_start),
    .usr_end   (usr_end),
    .usr_irq_n (usr_irq_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hst_sel = 1'b0; hst_rd = 1'b0; hst_addr = 4'h0;
    end_drv = 1'b0; tie = 1'b0; usr_irq_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 start", usr_start, 0);
    chk("R1 ack", hst_ack, 0);
    chk("R1 irq", hst_irq, 0);
    chk("R1 addr", usr_addr, 0);
    chk("R1 rd", usr_rd, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 start after release", usr_start, 0);
  endtask

  // one host cycle; user raises end w cycles after start is seen
  task automatic t_cycle(input logic [3:0] a, input logic rd, input int w, input int hold);
    hst_sel = 1'b1; hst_addr = a; hst_rd = rd;
    @(negedge clk);
    chk("R2 addr", usr_addr, a);
    chk("R2 rd", usr_rd, rd);
    chk("R2 start low in setup", usr_start, 0);
    hst_addr = ~a; hst_rd = ~rd;
    @(negedge clk);
    chk("R3 start", usr_start, 1);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      chk("R9 start held", usr_start, 1);
      chk("R9 ack low", hst_ack, 0);
      chk("R4 addr held", usr_addr, a);
    end
    end_drv = 1'b1;
    @(negedge clk);
    chk("R5 start before ack", usr_start, 1);
    @(negedge clk);
    chk("R5 ack not yet", hst_ack, 0);
    @(negedge clk);
    chk("R5 ack", hst_ack, 1);
    chk("R5 start drop", usr_start, 0);
    chk("R4 rd held", usr_rd, rd);
    end_drv = 1'b0;
    @(negedge clk);
    chk("R5 ack single", hst_ack, 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R7 no restart", usr_start, 0);
    end
    hst_sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_tied(input logic [3:0] a);
    int cnt;
    tie = 1'b1;
    hst_sel = 1'b1; hst_addr = a; hst_rd = 1'b1;
    cnt = 0;
    while (!hst_ack && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    chk("R6 tied latency", cnt, 5);
    chk("R6 addr", usr_addr, a);
    hst_sel = 1'b0;
    repeat (4) @(negedge clk);
    tie = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_irq();
    usr_irq_n = 1'b0;
    @(negedge clk);
    chk("R8 irq not yet", hst_irq, 0);
    @(negedge clk);
    chk("R8 irq set", hst_irq, 1);
    t_cycle(4'h9, 1'b1, 2, 0);
    chk("R8 irq held through cycle", hst_irq, 1);
    usr_irq_n = 1'b1;
    @(negedge clk);
    chk("R8 irq still set", hst_irq, 1);
    @(negedge clk);
    chk("R8 irq clear", hst_irq, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    t_reset();
    t_cycle(4'h5, 1'b0, 0, 0);
    t_cycle(4'hA, 1'b1, 3, 0);
    t_cycle(4'hF, 1'b0, 40, 5);
    t_cycle(4'h0, 1'b1, 1, 3);
    t_tied(4'h3);
    t_tied(4'hC);
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule